// File: doc/BRIEF.md
# Multi-bit sector error corrector

This block repairs one 512-byte sector after a multi-bit error decoder has found where the bad bits are. The sector arrives as a byte stream: 512 data bytes, followed at once by the 13 check bytes that protect them. The data bytes are kept in a local buffer, and the check bytes are counted and then discarded. Once all 525 bytes have been taken, the block waits for the decoder's answer. The answer is a 104-bit word that holds eight packed 13-bit bit offsets, together with a 4-bit error count.

For each offset, taken in index order up to the error count, the block inverts the two lowest bits of the offset. If the adjusted offset falls inside the sector, it flips the addressed bit with a read-modify-write on the buffer. It then raises a one-cycle done pulse carrying the number of corrections made, or it flags the sector as uncorrectable. While a correction is still pending, the block holds off the next sector by dropping its input ready. The repaired bytes can be read through a separate read port.

Top module: `ecc_sector_fixer`

## Requirements
- R1: The block takes a byte when in_valid and in_ready are both high. Bytes 0 to 511 of each sector are stored at buffer addresses 0 to 511, and bytes 512 to 524 (the check bytes) are dropped. After reset in_ready is 1, and it goes to 0 in the cycle after byte 524 is taken.
- R2: Error offset k (k = 0..7) is bits [13k+12:13k] of loc_word. Offset 0 is at the least significant end, and offset 4 straddles bits 63 and 64.
- R3: Each offset is XORed with 3 before it is used.
- R4: Adjusted offsets are handled as follows:
  - Below 4096: the offset flips bit (offset mod 8) of buffer byte (offset div 8) and counts as one correction.
  - Exactly 4096: the offset counts as one correction and leaves the buffer unchanged, because it points into the check bytes.
  - Above 4096: the offset is skipped and not counted.
- R5: A loc_count of 15 makes the block report uncorrectable=1 and fixed_count=0 with the done pulse. No buffer bit changes.
- R6: Offsets 0 to n-1 are processed in index order, where n = loc_count for counts 0..8 and n = 8 for counts 9..14. The offsets at index n and above have no effect.
- R7: done is a one-cycle pulse, and fixed_count and uncorrectable are valid while it is high. For a count of 0 or 15, done rises in the cycle after loc_valid is taken. Otherwise it rises 2 + C cycles after that, where C adds 2 for each flipped bit and 1 for each offset that is counted or skipped without a flip.
- R8: in_ready stays 0 from the end of a sector until the cycle in which done is high. Bytes offered during that time are not taken.
- R9: rd_data shows the buffer byte at rd_addr one clock after rd_addr is presented.
- R10: Two offsets that point at the same bit flip it twice, which leaves the bit unchanged, and both count as corrections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte (data, then check bytes) |
| in_ready | output | 1 | Block accepts a stream byte |
| loc_valid | input | 1 | Error location word and count are valid |
| loc_word | input | 104 | Eight packed 13-bit error offsets |
| loc_count | input | 4 | Number of errors, 15 = uncorrectable |
| rd_addr | input | 9 | Buffer read address |
| rd_data | output | 8 | Buffer read data, one cycle latency |
| done | output | 1 | Correction finished (one-cycle pulse) |
| fixed_count | output | 4 | Corrections made in the finished sector |
| uncorrectable | output | 1 | Finished sector could not be corrected |

## Verification
The bench predicts the clock cycle in which done rises for each correction request. It does this from the offsets it packed itself: one cycle for a count of 0 or 15, and otherwise two cycles plus two for each bit flip and one for each counted or skipped offset. On every falling edge after loc_valid, the bench compares done and in_ready with that prediction, and it checks the count and the flag only in the cycle in which done is due. While the correction runs, it keeps offering a stray byte to show that the hold-off works. Afterwards it reads back all 512 bytes, with one cycle of read latency, and compares them with a behavioural model of the buffer.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  typedef enum logic [1:0] {
    ST_LOAD,
    ST_WAIT,
    ST_FIX,
    ST_WR
  } fix_state_t;
endpackage

// File: rtl/sector_buf.sv
// Sector storage: one write port, two registered read ports (block RAM friendly).
module sector_buf #(
  parameter int DEPTH  = 512,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [7:0]        ra_data,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [7:0]        rb_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/loc_picker.sv
// Selects one packed error offset, inverts its two low bits and classifies it.
module loc_picker #(
  parameter int OFF_W = 13,
  parameter int NUM   = 8,
  parameter int LIMIT = 4096,
  parameter int IDX_W = $clog2(NUM + 1),
  parameter int SEL_W = $clog2(NUM)
) (
  input  logic [OFF_W*NUM-1:0] word,
  input  logic [IDX_W-1:0]     idx,
  output logic [OFF_W-1:0]     adj,
  output logic                 in_buf,
  output logic                 edge_hit
);
  logic [OFF_W-1:0] fields [NUM];
  logic [OFF_W-1:0] raw;

  for (genvar k = 0; k < NUM; k++) begin : g_unpack
    assign fields[k] = word[k*OFF_W +: OFF_W];
  end

  always_comb begin
    raw      = (idx < IDX_W'(NUM)) ? fields[idx[SEL_W-1:0]] : '0;
    adj      = raw ^ OFF_W'(3);
    in_buf   = adj < OFF_W'(LIMIT);
    edge_hit = adj == OFF_W'(LIMIT);
  end
endmodule

// File: rtl/ecc_sector_fixer.sv
module ecc_sector_fixer
  import ecc_fix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int ECC_BYTES    = 13,
  parameter int MAX_ERR      = 8,
  parameter int OFF_W        = 13,
  parameter int CNT_W        = 4,
  parameter int ADDR_W       = $clog2(SECTOR_BYTES),
  parameter int FIX_W        = $clog2(MAX_ERR + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [7:0]               in_data,
  output logic                     in_ready,
  input  logic                     loc_valid,
  input  logic [OFF_W*MAX_ERR-1:0] loc_word,
  input  logic [CNT_W-1:0]         loc_count,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  output logic                     done,
  output logic [FIX_W-1:0]         fixed_count,
  output logic                     uncorrectable
);
  localparam int STREAM    = SECTOR_BYTES + ECC_BYTES;
  localparam int SC_W      = $clog2(STREAM);
  localparam int WORD_W    = OFF_W * MAX_ERR;
  localparam int BIT_LIMIT = SECTOR_BYTES * 8;
  localparam logic [CNT_W-1:0] UNCORR = '1;

  fix_state_t        state;
  logic [SC_W-1:0]   byte_cnt;
  logic [WORD_W-1:0] word_q;
  logic [FIX_W-1:0]  n_q, idx_q, fix_q;
  logic [OFF_W-1:0]  adj;
  logic              in_buf, edge_hit;
  logic              buf_we;
  logic [ADDR_W-1:0] buf_waddr, fix_addr;
  logic [7:0]        buf_wdata, ra_data;
  logic [FIX_W-1:0]  n_eff;

  loc_picker #(.OFF_W(OFF_W), .NUM(MAX_ERR), .LIMIT(BIT_LIMIT), .IDX_W(FIX_W)) u_pick (
    .word(word_q), .idx(idx_q), .adj(adj), .in_buf(in_buf), .edge_hit(edge_hit)
  );

  assign fix_addr  = adj[ADDR_W+2:3];
  assign buf_we    = (state == ST_WR) ||
                     (state == ST_LOAD && in_valid && byte_cnt < SC_W'(SECTOR_BYTES));
  assign buf_waddr = (state == ST_WR) ? fix_addr : byte_cnt[ADDR_W-1:0];
  assign buf_wdata = (state == ST_WR) ? (ra_data ^ (8'b1 << adj[2:0])) : in_data;

  sector_buf #(.DEPTH(SECTOR_BYTES), .ADDR_W(ADDR_W)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .ra_addr(fix_addr), .ra_data(ra_data), .rb_addr(rd_addr), .rb_data(rd_data)
  );

  assign in_ready = (state == ST_LOAD);
  assign n_eff    = (loc_count > CNT_W'(MAX_ERR)) ? FIX_W'(MAX_ERR) : FIX_W'(loc_count);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_LOAD;
      byte_cnt      <= '0;
      word_q        <= '0;
      n_q           <= '0;
      idx_q         <= '0;
      fix_q         <= '0;
      done          <= 1'b0;
      fixed_count   <= '0;
      uncorrectable <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_LOAD: if (in_valid) begin
          if (byte_cnt == SC_W'(STREAM - 1)) begin
            byte_cnt <= '0;
            state    <= ST_WAIT;
          end else begin
            byte_cnt <= byte_cnt + SC_W'(1);
          end
        end
        ST_WAIT: if (loc_valid) begin
          word_q <= loc_word;
          idx_q  <= '0;
          fix_q  <= '0;
          n_q    <= n_eff;
          if (loc_count == UNCORR || loc_count == '0) begin
            done          <= 1'b1;
            uncorrectable <= (loc_count == UNCORR);
            fixed_count   <= '0;
            state         <= ST_LOAD;
          end else begin
            state <= ST_FIX;
          end
        end
        ST_FIX: begin
          if (idx_q == n_q) begin
            done          <= 1'b1;
            uncorrectable <= 1'b0;
            fixed_count   <= fix_q;
            state         <= ST_LOAD;
          end else if (in_buf) begin
            state <= ST_WR;
          end else begin
            if (edge_hit) fix_q <= fix_q + FIX_W'(1);
            idx_q <= idx_q + FIX_W'(1);
          end
        end
        ST_WR: begin
          fix_q <= fix_q + FIX_W'(1);
          idx_q <= idx_q + FIX_W'(1);
          state <= ST_FIX;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_idx_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIX) |-> (idx_q <= n_q));
  p_uncorr_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (done && uncorrectable) |-> (fixed_count == '0));
  p_hold_off_r8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_LOAD && in_valid) |=> $stable(byte_cnt));
  p_rmw_order_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WR) |-> ($past(state) == ST_FIX));
  p_fix_cap_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (fixed_count <= FIX_W'(MAX_ERR)));
endmodule

// File: tb/ecc_sector_fixer_bench.sv
module ecc_sector_fixer_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [7:0]   in_data = '0;
  logic         in_ready;
  logic         loc_valid = 1'b0;
  logic [103:0] loc_word = '0;
  logic [3:0]   loc_count = '0;
  logic [8:0]   rd_addr = '0;
  logic [7:0]   rd_data;
  logic         done;
  logic [3:0]   fixed_count;
  logic         uncorrectable;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_mem [512];

  always #10 clk = ~clk;

  ecc_sector_fixer u_ecc_sector_fixer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .loc_valid(loc_valid), .loc_word(loc_word), .loc_count(loc_count),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done),
    .fixed_count(fixed_count), .uncorrectable(uncorrectable)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [103:0] pack8(input int a0, a1, a2, a3, a4, a5, a6, a7);
    int a [8];
    logic [103:0] w;
    a = '{a0, a1, a2, a3, a4, a5, a6, a7};
    w = '0;
    for (int k = 0; k < 8; k++) w[13*k +: 13] = 13'(a[k] ^ 3);
    return w;
  endfunction

  // R1: 512 data bytes then 13 check bytes
  task automatic send_sector(input int seed);
    @(negedge clk);
    for (int i = 0; i < 525; i++) begin
      in_valid = 1'b1;
      in_data  = (i < 512) ? 8'((i * seed + 11) & 255) : 8'(8'hA0 + i);
      if (i < 512) exp_mem[i] = in_data;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R1 ready drops after sector", int'(in_ready), 0);
  endtask

  task automatic run_fix(input logic [103:0] w, input int cnt, input string tag);
    int n, fixed, cost, d;
    bit unc;
    logic [12:0] a;
    unc = (cnt == 15);
    n = (cnt > 8) ? 8 : cnt;
    fixed = 0;
    cost = 0;
    if (!unc) begin
      for (int k = 0; k < n; k++) begin
        a = w[13*k +: 13] ^ 13'd3;
        if (a < 4096) begin
          exp_mem[a >> 3] ^= 8'(1 << a[2:0]);
          fixed++;
          cost += 2;
        end else if (a == 4096) begin
          fixed++;
          cost += 1;
        end else begin
          cost += 1;
        end
      end
    end
    d = (cnt == 0 || unc) ? 1 : cost + 2;
    loc_valid = 1'b1;
    loc_word  = w;
    loc_count = 4'(cnt);
    in_valid  = 1'b1;
    in_data   = 8'hEE;
    for (int e = 1; e <= d + 2; e++) begin
      @(negedge clk);
      if (e == 1) loc_valid = 1'b0;
      check(done == (e == d), {tag, " R7 done timing"}, int'(done), int'(e == d));
      check(in_ready == (e >= d), {tag, " R8 hold-off ready"}, int'(in_ready), int'(e >= d));
      if (e == d) begin
        check(fixed_count == 4'(fixed), {tag, " R4 fixed count"}, int'(fixed_count), fixed);
        check(uncorrectable == unc, {tag, " R5 uncorrectable flag"}, int'(uncorrectable), int'(unc));
        in_valid = 1'b0;
      end
    end
  endtask

  // R9: registered readback, one cycle latency
  task automatic verify_sector(input string tag);
    int miss, first_a;
    int act, exp;
    miss = 0;
    first_a = 0;
    act = 0;
    exp = 0;
    for (int a = 0; a < 512; a++) begin
      rd_addr = 9'(a);
      @(negedge clk);
      if (rd_data !== exp_mem[a]) begin
        if (miss == 0) begin
          first_a = a;
          act = int'(rd_data);
          exp = int'(exp_mem[a]);
        end
        miss++;
      end
    end
    check(miss == 0, {tag, " R9 sector content"}, act, exp);
    if (miss != 0) $display("  first bad byte at %0d, %0d bytes differ", first_a, miss);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    check(done == 1'b0, "R7 done low after reset", int'(done), 0);

    send_sector(7);
    run_fix(pack8(1, 2, 3, 4, 5, 6, 7, 9), 0, "R6 zero count");
    verify_sector("R6 zero count");

    send_sector(13);
    run_fix(pack8(0, 4095, 100, 200, 300, 400, 500, 600), 3, "R3 xor and order");
    verify_sector("R3 xor and order");

    send_sector(5);
    run_fix(pack8(1, 2, 3, 0, 0, 0, 0, 0), 15, "R5 uncorrectable");
    verify_sector("R5 uncorrectable");

    send_sector(9);
    run_fix(pack8(5000, 4096, 8, 0, 0, 0, 0, 0), 3, "R4 range");
    verify_sector("R4 range");

    send_sector(3);
    run_fix(pack8(10, 300, 1234, 2047, 4096, 3000, 3999, 7), 8, "R2 field 4 straddle");
    verify_sector("R2 field 4 straddle");

    send_sector(21);
    run_fix(pack8(1, 2, 3, 4, 4000, 2222, 1111, 777), 11, "R6 capped count");
    verify_sector("R6 capped count");

    send_sector(17);
    run_fix(pack8(555, 555, 0, 0, 0, 0, 0, 0), 2, "R10 double flip");
    verify_sector("R10 double flip");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule